// File: doc/BRIEF.md
# Dual-Channel Data-Ready Combiner

This block sits behind two sampling converter channels and merges their per-sample ready strobes into a single active-low data-ready pin. Each channel also hands over its sample word with the strobe. A two-bit mode input selects which strobes reach the pin: channel 0 alone, channel 1 alone, every strobe from either channel, or a linked mode in which both channels act as one. In linked mode the block remembers which channel has already delivered a sample. When the later (lagging) channel delivers, it emits one pulse and loads both output words together, so a host reading on that pulse always gets a matched pair.

Each channel has a reset-or-shutdown flag. A channel whose flag is high contributes nothing. In linked mode, either flag being high silences the pin and drops any half-formed pair. The ready strobes behave like a valid-only stream. The converters cannot be stalled, so there is no ready/back-pressure return path. A strobe is consumed in the cycle it is high, and a host that misses a pulse reads the newer word next time. The mode input and the shutdown flags are plain level controls.

Top module: `drdy_combiner`

## Requirements
- R1: After reset, `drdy_n` is high, both output words are zero, and no linked-mode sample is pending: a lone channel 1 strobe in linked mode right after reset produces no pulse.
- R2: Each pulse drives `drdy_n` low for exactly one clock cycle, in the cycle after the clock edge that samples the causing strobe. The output words the pulse refers to are valid in that same cycle.
- R3: Mode `2'b11` pulses for every accepted strobe of either channel. When both channels strobe in the same cycle, only one single-cycle pulse is emitted.
- R4: Mode `2'b01` pulses only for channel 0 strobes. Channel 1 strobes produce no pulse.
- R5: Mode `2'b10` pulses only for channel 1 strobes. Channel 0 strobes produce no pulse.
- R6: Mode `2'b00` (linked) emits one pulse per sample pair, when the later of the two channels strobes. Both output words are loaded together on that pulse, each with its channel's most recent sample. Same-cycle strobes form a pair at once.
- R7: In mode `2'b00`, no pulse is produced while either shutdown flag is high. Raising a flag also discards any channel that had already delivered, so a later strobe from the partner alone does not pulse.
- R8: In mode `2'b11`, a channel with its shutdown flag low keeps pulsing while the other channel's flag is high.
- R9: A strobe from a channel whose shutdown flag is high is ignored. It produces no pulse and leaves that channel's output word unchanged.
- R10: In modes `2'b01`, `2'b10` and `2'b11`, each output word is loaded on its own channel's accepted strobe, even when that channel's pulse is not routed to the pin.
- R11: Any change of the mode input discards pending linked-mode samples. After leaving and re-entering mode `2'b00`, the partner's strobe alone does not pulse.
- R12: In mode `2'b00`, repeated strobes from one channel before its partner produce no pulse. The pair pulse then carries that channel's latest word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch0_strb | input | 1 | Channel 0 single-cycle sample-ready strobe (valid) |
| ch0_word | input | 24 | Channel 0 sample word, meaningful with `ch0_strb` |
| ch0_off | input | 1 | Channel 0 held in reset or shutdown |
| ch1_strb | input | 1 | Channel 1 single-cycle sample-ready strobe (valid) |
| ch1_word | input | 24 | Channel 1 sample word, meaningful with `ch1_strb` |
| ch1_off | input | 1 | Channel 1 held in reset or shutdown |
| mode | input | 2 | 00 linked, 01 channel 0, 10 channel 1, 11 both |
| drdy_n | output | 1 | Combined data-ready pin, active low |
| ch0_data | output | 24 | Channel 0 output word |
| ch1_data | output | 24 | Channel 1 output word |

## Verification
Every result of this block has the same latency. Both the pin pulse and any output-word load appear one cycle after the rising edge that samples the strobe, shutdown flags and mode. A linked pair is due one cycle after the lagging strobe, however far apart the two strobes arrive. The driver applies each cycle's inputs on the falling edge and computes the expected pin and words for that cycle. It queues them just after the next rising edge. The monitor pops and compares on the falling edge that follows, which is exactly the cycle in which the registered results must be visible.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_LINK = 2'b00,
    MODE_CH0  = 2'b01,
    MODE_CH1  = 2'b10,
    MODE_BOTH = 2'b11
  } drdy_mode_e;
endpackage

// File: rtl/drdy_stage.sv
module drdy_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb,
  input  logic         off,
  input  logic [W-1:0] word,
  output logic         evt,
  output logic [W-1:0] held
);
  assign evt = strb & ~off;

  always_ff @(posedge clk) begin
    if (!rst_n)   held <= '0;
    else if (evt) held <= word;
  end

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && off) |=> $stable(held));
endmodule

// File: rtl/drdy_pair.sv
module drdy_pair
  import drdy_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           link,
  input  logic           mode_chg,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] off,
  output logic           fire
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] keep;
  logic [NCH-1:0] avail;

  always_comb begin
    keep  = pend & {NCH{~mode_chg}};
    avail = keep | evt;
    fire  = link & (&avail) & ~(|off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         pend <= '0;
    else if (fire || (|off) || !link)   pend <= '0;
    else                                pend <= avail;
  end

  // R6
  pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend == '0));
  // R7
  off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|off) |=> (pend == '0));
endmodule

// File: rtl/drdy_select.sv
module drdy_select
  import drdy_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic [NCH-1:0]         evt,
  input  logic                   fire,
  input  logic [NCH-1:0][W-1:0]  word,
  input  logic [NCH-1:0][W-1:0]  held,
  output logic                   drdy_n,
  output logic [NCH-1:0][W-1:0]  data
);
  drdy_mode_e md;
  logic       pulse;

  always_comb begin
    md = drdy_mode_e'(mode);
    unique case (md)
      MODE_BOTH: pulse = |evt;
      MODE_CH1:  pulse = evt[1];
      MODE_CH0:  pulse = evt[0];
      default:   pulse = fire;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drdy_n <= 1'b1;
    else        drdy_n <= ~pulse;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    logic load;
    assign load = (md == MODE_LINK) ? fire : evt[i];
    always_ff @(posedge clk) begin
      if (!rst_n)    data[i] <= '0;
      else if (load) data[i] <= evt[i] ? word[i] : held[i];
    end
  end

  // R2
  data_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MODE_LINK && !fire) |=> $stable(data));
endmodule

// File: rtl/drdy_combiner.sv
module drdy_combiner
  import drdy_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ch0_strb,
  input  logic [W-1:0] ch0_word,
  input  logic         ch0_off,
  input  logic         ch1_strb,
  input  logic [W-1:0] ch1_word,
  input  logic         ch1_off,
  input  logic [1:0]   mode,
  output logic         drdy_n,
  output logic [W-1:0] ch0_data,
  output logic [W-1:0] ch1_data
);
  logic [NCH-1:0]        strb_v, off_v, evt;
  logic [NCH-1:0][W-1:0] word_v, held_v, data_v;
  logic [1:0]            mode_q;
  logic                  mode_chg, fire;

  assign strb_v = {ch1_strb, ch0_strb};
  assign off_v  = {ch1_off, ch0_off};
  assign word_v = {ch1_word, ch0_word};

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_LINK;
    else        mode_q <= mode;
  end
  assign mode_chg = (mode != mode_q);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    drdy_stage #(.W(W)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .strb (strb_v[i]),
      .off  (off_v[i]),
      .word (word_v[i]),
      .evt  (evt[i]),
      .held (held_v[i])
    );
  end

  drdy_pair u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .link    (mode == MODE_LINK),
    .mode_chg(mode_chg),
    .evt     (evt),
    .off     (off_v),
    .fire    (fire)
  );

  drdy_select #(.W(W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .evt   (evt),
    .fire  (fire),
    .word  (word_v),
    .held  (held_v),
    .drdy_n(drdy_n),
    .data  (data_v)
  );

  assign ch0_data = data_v[0];
  assign ch1_data = data_v[1];

  // R7
  link_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LINK && (ch0_off || ch1_off)) |=> drdy_n);
  // R4
  ch0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CH0 && !(ch0_strb && !ch0_off)) |=> drdy_n);
  // R5
  ch1_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CH1 && !(ch1_strb && !ch1_off)) |=> drdy_n);
  // R8
  awake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BOTH && ((ch0_strb && !ch0_off) || (ch1_strb && !ch1_off))) |=> !drdy_n);
endmodule

// File: tb/test_drdy_combiner.sv
`timescale 1ns/1ps
module test_drdy_combiner;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         s0, s1, o0, o1;
  logic [W-1:0] w0, w1;
  logic [1:0]   md;
  logic         drdy_n;
  logic [W-1:0] d0, d1;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  drdy_combiner #(.W(W)) i_drdy_combiner (
    .clk(clk), .rst_n(rst_n),
    .ch0_strb(s0), .ch0_word(w0), .ch0_off(o0),
    .ch1_strb(s1), .ch1_word(w1), .ch1_off(o1),
    .mode(md), .drdy_n(drdy_n), .ch0_data(d0), .ch1_data(d1)
  );

  // scoreboard queues
  logic         q_dn[$];
  logic [W-1:0] q_d0[$];
  logic [W-1:0] q_d1[$];
  string        q_tag[$];

  // reference state
  logic [1:0]   m_seen;
  logic [W-1:0] m_stg0, m_stg1, m_out0, m_out1;
  logic [1:0]   m_pm;

  task automatic step(input logic a0, input logic [W-1:0] b0, input logic c0,
                      input logic a1, input logic [W-1:0] b1, input logic c1,
                      input logic [1:0] m, input string tag);
    logic e0, e1, chg, v0, v1, fire, pulse;
    @(negedge clk);
    s0 = a0; w0 = b0; o0 = c0; s1 = a1; w1 = b1; o1 = c1; md = m;
    e0 = a0 & ~c0;
    e1 = a1 & ~c1;
    chg = (m != m_pm);
    v0 = (m_seen[0] & ~chg) | e0;
    v1 = (m_seen[1] & ~chg) | e1;
    fire = (m == 2'b00) & v0 & v1 & ~c0 & ~c1;
    case (m)
      2'b11:   pulse = e0 | e1;
      2'b10:   pulse = e1;
      2'b01:   pulse = e0;
      default: pulse = fire;
    endcase
    if (m == 2'b00) begin
      if (fire) begin
        m_out0 = e0 ? b0 : m_stg0;
        m_out1 = e1 ? b1 : m_stg1;
      end
    end else begin
      if (e0) m_out0 = b0;
      if (e1) m_out1 = b1;
    end
    if (e0) m_stg0 = b0;
    if (e1) m_stg1 = b1;
    if (fire || c0 || c1 || m != 2'b00) m_seen = 2'b00;
    else                                m_seen = {v1, v0};
    m_pm = m;
    @(posedge clk);
    #1;
    q_dn.push_back(~pulse);
    q_d0.push_back(m_out0);
    q_d1.push_back(m_out1);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input logic c0, input logic c1,
                      input logic [1:0] m, input string tag);
    for (int k = 0; k < n; k++) step(0, '0, c0, 0, '0, c1, m, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic         edn;
      logic [W-1:0] e0v, e1v;
      string        t;
      edn = q_dn.pop_front();
      e0v = q_d0.pop_front();
      e1v = q_d1.pop_front();
      t   = q_tag.pop_front();
      nchk++;
      if (drdy_n !== edn || d0 !== e0v || d1 !== e1v) begin
        nerr++;
        $display("FAIL %s: drdy_n=%b ch0=%h ch1=%h expected drdy_n=%b ch0=%h ch1=%h",
                 t, drdy_n, d0, d1, edn, e0v, e1v);
      end
    end
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    s0 = 0; s1 = 0; o0 = 0; o1 = 0; w0 = '0; w1 = '0; md = 2'b00;
    m_seen = 2'b00; m_stg0 = '0; m_stg1 = '0; m_out0 = '0; m_out1 = '0; m_pm = 2'b00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    nchk++;
    if (drdy_n !== 1'b1 || d0 !== '0 || d1 !== '0) begin
      nerr++;
      $display("FAIL R1: drdy_n=%b ch0=%h ch1=%h expected 1 0 0", drdy_n, d0, d1);
    end
    // R1: nothing pending, lone ch1 strobe must not pulse
    step(0, '0, 0, 1, 24'h11_1111, 0, 2'b00, "R1");
    idle(2, 0, 0, 2'b00, "R1");

    // R4 / R10 mode 01
    step(1, 24'hA0_0001, 0, 0, '0, 0, 2'b01, "R4");
    idle(1, 0, 0, 2'b01, "R2");
    step(0, '0, 0, 1, 24'hB0_0001, 0, 2'b01, "R10");
    idle(1, 0, 0, 2'b01, "R4");

    // R5 / R10 mode 10
    step(0, '0, 0, 1, 24'hB0_0002, 0, 2'b10, "R5");
    step(1, 24'hA0_0002, 0, 0, '0, 0, 2'b10, "R10");
    idle(1, 0, 0, 2'b10, "R5");

    // R3 mode 11
    step(1, 24'hA0_0003, 0, 0, '0, 0, 2'b11, "R3");
    step(0, '0, 0, 1, 24'hB0_0003, 0, 2'b11, "R3");
    idle(1, 0, 0, 2'b11, "R2");
    step(1, 24'hA0_0004, 0, 1, 24'hB0_0004, 0, 2'b11, "R3");
    idle(1, 0, 0, 2'b11, "R3");

    // R8 / R9 mode 11, channel 1 asleep
    step(1, 24'hA0_0005, 0, 0, '0, 1, 2'b11, "R8");
    step(0, '0, 0, 1, 24'hDEAD_01, 1, 2'b11, "R9");
    idle(1, 0, 1, 2'b11, "R9");
    step(1, 24'hDEAD_02, 1, 0, '0, 0, 2'b11, "R9");
    idle(1, 0, 0, 2'b11, "R9");

    // R6 linked: ch0 leads, ch1 lags by 3
    idle(1, 0, 0, 2'b00, "R11");
    step(1, 24'hA0_0006, 0, 0, '0, 0, 2'b00, "R6");
    idle(2, 0, 0, 2'b00, "R6");
    step(0, '0, 0, 1, 24'hB0_0006, 0, 2'b00, "R6");
    idle(1, 0, 0, 2'b00, "R6");
    // R6 ch1 leads
    step(0, '0, 0, 1, 24'hB0_0007, 0, 2'b00, "R6");
    step(1, 24'hA0_0007, 0, 0, '0, 0, 2'b00, "R6");
    // R6 same cycle
    step(1, 24'hA0_0008, 0, 1, 24'hB0_0008, 0, 2'b00, "R6");
    idle(1, 0, 0, 2'b00, "R6");

    // R12 repeated leader
    step(1, 24'hA0_0009, 0, 0, '0, 0, 2'b00, "R12");
    step(1, 24'hA0_000A, 0, 0, '0, 0, 2'b00, "R12");
    idle(1, 0, 0, 2'b00, "R12");
    step(0, '0, 0, 1, 24'hB0_000A, 0, 2'b00, "R12");

    // R7 shutdown drops pending and silences
    step(1, 24'hA0_000B, 0, 0, '0, 0, 2'b00, "R7");
    idle(2, 0, 1, 2'b00, "R7");
    step(1, 24'hA0_000C, 0, 0, '0, 1, 2'b00, "R7");
    idle(1, 0, 0, 2'b00, "R7");
    step(0, '0, 0, 1, 24'hB0_000C, 0, 2'b00, "R7");
    idle(1, 0, 0, 2'b00, "R7");
    step(1, 24'hA0_000D, 0, 0, '0, 0, 2'b00, "R7");

    // R11 mode change drops pending
    step(1, 24'hA0_000E, 0, 0, '0, 0, 2'b00, "R11");
    idle(1, 0, 0, 2'b01, "R11");
    idle(1, 0, 0, 2'b00, "R11");
    step(0, '0, 0, 1, 24'hB0_000E, 0, 2'b00, "R11");
    idle(2, 0, 0, 2'b00, "R11");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule